// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block is a watchdog counter advanced by a single-cycle tick from a slow low-power clock. The tick arrives as an enable in the system clock domain, so the whole block runs on one clock. A two-way prescaler divides the tick stream. A power-of-two postscaler, chosen by a 4-bit select, stretches the prescaler output into the timeout period. When the watchdog is enabled and nothing restarts it, reaching the end of the period raises one action. In normal operation that action is a one-cycle device-reset request. When the core is in a low-power mode, it is a one-cycle wake-up request instead.

The counts restart on several events: a clear command, entry into or exit from a power-save mode, the completion of a clock switch, and the block's own reset. With window mode active, a clear that comes before the final quarter of the period counts as a fault and raises a reset request. A sticky flag records every timeout until software removes it.

Top module: `wdt_windowed`

## Requirements
- R1: The prescaler length in ticks is 2^SHORT_LOG when `long_pre_i` is 0 and 2^LONG_LOG when it is 1 (defaults 32 and 128).
- R2: The timeout period in ticks is the prescaler length times 2^`post_sel_i`, for every one of the 16 select codes 0 to 15.
- R3: With `low_power_i` low, a timeout drives `rst_req_o` high for exactly one cycle. The output rises on the clock edge that samples the last tick of the period, and a fresh full period then starts from zero.
- R4: A clear command (`clr_i`), `ps_enter_i`, `ps_exit_i` or `clk_sw_done_i` restarts both counts from zero. The next timeout then needs a full period.
- R5: The watchdog runs whenever `hw_en_i` is 1. When `hw_en_i` is 0, it runs only while `sw_en_i` is 1.
- R6: While disabled, both counts are held at zero, and neither `rst_req_o` nor `wake_o` is raised.
- R7: With `win_dis_i` at 0, a clear sampled while fewer than three quarters of the period's ticks have elapsed raises `rst_req_o` on the next cycle. A later clear, including one on the last tick, is accepted without a reset and cancels that tick's timeout.
- R8: With `win_dis_i` at 1, a clear is accepted at any point in the period and never raises a reset.
- R9: With `low_power_i` high, a timeout drives `wake_o` high for one cycle instead of `rst_req_o`. The two outputs are never high together.
- R10: `flag_o` sets on every timeout, in either mode. It holds until a `flag_clr_i` cycle that has no simultaneous timeout, and it is 0 after reset.
- R11: The counts advance only on cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high device reset |
| tick_i | input | 1 | One-cycle enable from the low-power clock |
| hw_en_i | input | 1 | Hardware strap forcing the watchdog on |
| sw_en_i | input | 1 | Software enable, used when the strap is 0 |
| long_pre_i | input | 1 | Prescaler select: 0 short, 1 long |
| post_sel_i | input | SEL_W | Postscaler exponent, ratio 2^value |
| win_dis_i | input | 1 | 1 turns window mode off |
| clr_i | input | 1 | Clear-watchdog command pulse |
| ps_enter_i | input | 1 | Power-save entry pulse |
| ps_exit_i | input | 1 | Power-save exit pulse |
| clk_sw_done_i | input | 1 | Clock-switch completion pulse |
| low_power_i | input | 1 | Core is in sleep or idle |
| flag_clr_i | input | 1 | Software clear of the timeout flag |
| rst_req_o | output | 1 | One-cycle device-reset request |
| wake_o | output | 1 | One-cycle wake-up request |
| flag_o | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with SHORT_LOG = 2 and LONG_LOG = 3, which gives prescaler lengths of 4 and 8 ticks. SEL_W keeps its default of 4, so the postscaler is still the full 15-bit counter. With these values a 1:4 period takes 16 ticks, and exact timeout cycles can be counted within a few dozen clocks. The window boundary at tick 12 can be probed from both sides, and so can a clear on the terminal tick. Long-prescaler and larger postscaler settings (up to 256 ticks) confirm that the two scalers combine correctly without long runs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Registered action the watchdog raises at the end of a period.
    typedef enum logic [1:0] {
        WDT_ACT_NONE  = 2'd0,
        WDT_ACT_RESET = 2'd1,
        WDT_ACT_WAKE  = 2'd2
    } wdt_act_e;

    // System events that restart the counts.
    typedef struct packed {
        logic clk_switch;
        logic ps_enter;
        logic ps_exit;
    } wdt_sys_evt_t;

    // Where the combined count stands inside the current period.
    typedef struct packed {
        logic at_terminal;
        logic window_open;
    } wdt_phase_t;

    // log2 of the prescaler length for a given select.
    function automatic int pre_log(input logic long_sel, input int short_log,
                                   input int long_log);
        return long_sel ? long_log : short_log;
    endfunction

    // Any system event present.
    function automatic logic any_sys_evt(input wdt_sys_evt_t e);
        return e.clk_switch | e.ps_enter | e.ps_exit;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int SHORT_LOG = 5,
    parameter int LONG_LOG  = 7,
    localparam int W = LONG_LOG
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         restart_i,
    input  logic         step_i,
    input  logic         long_sel_i,
    output logic [W-1:0] count_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] SHORT_MAX = W'((1 << SHORT_LOG) - 1);
    localparam logic [W-1:0] LONG_MAX  = '1;

    logic [W-1:0] count_q;
    logic [W-1:0] cur_max;

    assign cur_max = long_sel_i ? LONG_MAX : SHORT_MAX;
    assign wrap_o  = step_i && (count_q == cur_max);
    assign count_o = count_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) begin
            count_q <= '0;
        end else if (step_i) begin
            count_q <= wrap_o ? '0 : count_q + W'(1);
        end
    end

    AST_PRE_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
        restart_i |=> (count_o == '0)); // R4

    AST_PRE_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!restart_i && !step_i) |=> $stable(count_o)); // R11

endmodule

// File: rtl/wdt_postscaler.sv
module wdt_postscaler #(
    parameter int SEL_W = 4,
    localparam int W = (1 << SEL_W) - 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             restart_i,
    input  logic             step_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [W-1:0]     count_o
);
    logic [W-1:0] count_q;
    logic [W-1:0] cur_max;
    logic         wrap;

    // Terminal value 2^sel - 1; a shift by W leaves all ones.
    assign cur_max = ~({W{1'b1}} << sel_i);
    assign wrap    = step_i && (count_q == cur_max);
    assign count_o = count_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) begin
            count_q <= '0;
        end else if (step_i) begin
            count_q <= wrap ? '0 : count_q + W'(1);
        end
    end

    AST_POST_RESTART: assert property (@(posedge clk_i) disable iff (rst_i)
        restart_i |=> (count_o == '0)); // R4

    AST_POST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (wrap && !restart_i) |=> (count_o == '0)); // R2

endmodule

// File: rtl/wdt_window.sv
module wdt_window
    import wdt_pkg::*;
#(
    parameter int SHORT_LOG = 5,
    parameter int LONG_LOG  = 7,
    parameter int SEL_W     = 4,
    localparam int POST_W = (1 << SEL_W) - 1,
    localparam int EW     = LONG_LOG + POST_W,
    localparam int IW     = $clog2(EW)
) (
    input  logic [LONG_LOG-1:0] pre_count_i,
    input  logic [POST_W-1:0]   post_count_i,
    input  logic                long_sel_i,
    input  logic [SEL_W-1:0]    post_sel_i,
    output wdt_phase_t          phase_o
);
    logic [EW-1:0] elapsed;
    logic [EW-1:0] end_mask;
    logic [IW-1:0] hi_idx;
    logic [IW-1:0] lo_idx;
    int            shift_amt;
    int            span;

    // Elapsed ticks in the period = post * prescaler_len + pre.
    // The period is 2^span ticks; the last quarter is where the top two
    // bits of that span are both set.
    always_comb begin
        shift_amt = pre_log(long_sel_i, SHORT_LOG, LONG_LOG);
        span      = shift_amt + int'(post_sel_i);
        elapsed   = (EW'(post_count_i) << shift_amt) | EW'(pre_count_i);
        end_mask  = ~({EW{1'b1}} << span);
        hi_idx    = IW'(span - 1);
        lo_idx    = IW'(span - 2);
        phase_o.window_open = elapsed[hi_idx] & elapsed[lo_idx];
        phase_o.at_terminal = (elapsed == end_mask);
    end

endmodule

// File: rtl/wdt_action.sv
module wdt_action
    import wdt_pkg::*;
(
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    input  logic         tick_i,
    input  logic         low_power_i,
    input  logic         win_dis_i,
    input  logic         clr_i,
    input  wdt_sys_evt_t sys_evt_i,
    input  wdt_phase_t   phase_i,
    input  logic         flag_clr_i,
    output logic         restart_o,
    output logic         rst_req_o,
    output logic         wake_o,
    output logic         flag_o
);
    wdt_act_e act_d, act_q;
    logic     sys_clear;
    logic     clr_seen;
    logic     early_clr;
    logic     timeout;
    logic     flag_q;

    always_comb begin
        sys_clear = any_sys_evt(sys_evt_i);
        clr_seen  = en_i & clr_i;
        early_clr = clr_seen & ~win_dis_i & ~phase_i.window_open;
        // An accepted clear or system event on the final tick wins.
        timeout   = en_i & tick_i & phase_i.at_terminal & ~clr_i & ~sys_clear;
        restart_o = ~en_i | clr_i | sys_clear;

        act_d = WDT_ACT_NONE;
        if (early_clr || (timeout && !low_power_i)) begin
            act_d = WDT_ACT_RESET;
        end else if (timeout) begin
            act_d = WDT_ACT_WAKE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            act_q  <= WDT_ACT_NONE;
            flag_q <= 1'b0;
        end else begin
            act_q <= act_d;
            if (timeout) begin
                flag_q <= 1'b1;
            end else if (flag_clr_i) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign rst_req_o = (act_q == WDT_ACT_RESET);
    assign wake_o    = (act_q == WDT_ACT_WAKE);
    assign flag_o    = flag_q;

    AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (rst_i)
        !(rst_req_o && wake_o)); // R9

    AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> (!rst_req_o && !wake_o)); // R6

    AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (flag_o && !flag_clr_i) |=> flag_o); // R10

    AST_EARLY_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && clr_i && !win_dis_i && !phase_i.window_open) |=> rst_req_o); // R7

    AST_NO_CLEAR_FAULT: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_i && clr_i && win_dis_i) |=> !rst_req_o); // R8

endmodule

// File: rtl/wdt_windowed.sv
module wdt_windowed
    import wdt_pkg::*;
#(
    parameter int SHORT_LOG = 5,
    parameter int LONG_LOG  = 7,
    parameter int SEL_W     = 4,
    localparam int POST_W = (1 << SEL_W) - 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic             hw_en_i,
    input  logic             sw_en_i,
    input  logic             long_pre_i,
    input  logic [SEL_W-1:0] post_sel_i,
    input  logic             win_dis_i,
    input  logic             clr_i,
    input  logic             ps_enter_i,
    input  logic             ps_exit_i,
    input  logic             clk_sw_done_i,
    input  logic             low_power_i,
    input  logic             flag_clr_i,
    output logic             rst_req_o,
    output logic             wake_o,
    output logic             flag_o
);
    logic                en;
    logic                run_tick;
    logic                restart;
    logic                pre_wrap;
    logic [LONG_LOG-1:0] pre_count;
    logic [POST_W-1:0]   post_count;
    wdt_sys_evt_t        sys_evt;
    wdt_phase_t          phase;

    assign en       = hw_en_i | sw_en_i;
    assign run_tick = en & tick_i;

    always_comb begin
        sys_evt.clk_switch = clk_sw_done_i;
        sys_evt.ps_enter   = ps_enter_i;
        sys_evt.ps_exit    = ps_exit_i;
    end

    wdt_prescaler #(
        .SHORT_LOG (SHORT_LOG),
        .LONG_LOG  (LONG_LOG)
    ) u_pre (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .restart_i  (restart),
        .step_i     (run_tick),
        .long_sel_i (long_pre_i),
        .count_o    (pre_count),
        .wrap_o     (pre_wrap)
    );

    wdt_postscaler #(
        .SEL_W (SEL_W)
    ) u_post (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .restart_i (restart),
        .step_i    (pre_wrap),
        .sel_i     (post_sel_i),
        .count_o   (post_count)
    );

    wdt_window #(
        .SHORT_LOG (SHORT_LOG),
        .LONG_LOG  (LONG_LOG),
        .SEL_W     (SEL_W)
    ) u_win (
        .pre_count_i  (pre_count),
        .post_count_i (post_count),
        .long_sel_i   (long_pre_i),
        .post_sel_i   (post_sel_i),
        .phase_o      (phase)
    );

    wdt_action u_act (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .en_i        (en),
        .tick_i      (tick_i),
        .low_power_i (low_power_i),
        .win_dis_i   (win_dis_i),
        .clr_i       (clr_i),
        .sys_evt_i   (sys_evt),
        .phase_i     (phase),
        .flag_clr_i  (flag_clr_i),
        .restart_o   (restart),
        .rst_req_o   (rst_req_o),
        .wake_o      (wake_o),
        .flag_o      (flag_o)
    );

    AST_HELD_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !en |=> (pre_count == '0 && post_count == '0)); // R6

    AST_LP_WAKE_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
        (low_power_i && !clr_i) |=> !rst_req_o); // R9

endmodule

// File: tb/sim_wdt_windowed.sv
module sim_wdt_windowed;
    localparam int SEL_W = 4;

    logic             clk = 1'b0;
    logic             rst_i = 1'b1;
    logic             tick_i;
    logic             hw_en_i = 1'b1;
    logic             sw_en_i = 1'b0;
    logic             long_pre_i = 1'b0;
    logic [SEL_W-1:0] post_sel_i = 4'd2;
    logic             win_dis_i = 1'b1;
    logic             clr_i = 1'b0;
    logic             ps_enter_i = 1'b0;
    logic             ps_exit_i = 1'b0;
    logic             clk_sw_done_i = 1'b0;
    logic             low_power_i = 1'b0;
    logic             flag_clr_i = 1'b0;
    logic             rst_req_o, wake_o, flag_o;

    logic tick_gap = 1'b0;
    logic tick_phase = 1'b0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) tick_phase <= ~tick_phase;
    assign tick_i = tick_gap ? tick_phase : 1'b1;

    wdt_windowed #(.SHORT_LOG(2), .LONG_LOG(3), .SEL_W(SEL_W)) u0 (
        .clk_i(clk), .rst_i(rst_i), .tick_i(tick_i), .hw_en_i(hw_en_i),
        .sw_en_i(sw_en_i), .long_pre_i(long_pre_i), .post_sel_i(post_sel_i),
        .win_dis_i(win_dis_i), .clr_i(clr_i), .ps_enter_i(ps_enter_i),
        .ps_exit_i(ps_exit_i), .clk_sw_done_i(clk_sw_done_i),
        .low_power_i(low_power_i), .flag_clr_i(flag_clr_i),
        .rst_req_o(rst_req_o), .wake_o(wake_o), .flag_o(flag_o));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_i = 1'b1;
        repeat (2) @(negedge clk);
        rst_i = 1'b0;
    endtask

    task automatic advance(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Edges until rst_req_o or wake_o is seen (limit caps the wait).
    task automatic measure(output int n, input int limit);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (rst_req_o || wake_o) break;
        end
    endtask

    task automatic pulse_clr();
        clr_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr_i = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check(!rst_req_o && !wake_o, "R3 reset idle outputs", int'(rst_req_o | wake_o), 0);
        check(!flag_o, "R10 flag clear after reset", int'(flag_o), 0);
    endtask

    task automatic t_prescaler();
        int n;
        post_sel_i = 4'd0; long_pre_i = 1'b0; do_reset();
        measure(n, 100);
        check(n == 4, "R1 short prescaler period", n, 4);
        long_pre_i = 1'b1; do_reset();
        measure(n, 100);
        check(n == 8, "R1 long prescaler period", n, 8);
    endtask

    task automatic t_postscaler();
        int n;
        long_pre_i = 1'b0; post_sel_i = 4'd3; do_reset();
        measure(n, 200);
        check(n == 32, "R2 postscaler 1:8 short", n, 32);
        long_pre_i = 1'b1; post_sel_i = 4'd5; do_reset();
        measure(n, 600);
        check(n == 256, "R2 postscaler 1:32 long", n, 256);
        long_pre_i = 1'b0; post_sel_i = 4'd2;
    endtask

    task automatic t_run_timeout();
        int n;
        do_reset();
        measure(n, 100);
        check(n == 16 && rst_req_o && !wake_o, "R3 run-mode timeout", n, 16);
        check(flag_o, "R10 flag set on run timeout", int'(flag_o), 1);
        advance(1);
        check(!rst_req_o, "R3 reset request one cycle", int'(rst_req_o), 0);
        measure(n, 100);
        check(n == 15, "R3 restart from zero", n, 15);
    endtask

    task automatic t_window();
        int n;
        win_dis_i = 1'b0;
        do_reset(); advance(11); pulse_clr();
        check(rst_req_o, "R7 early clear resets", int'(rst_req_o), 1);
        measure(n, 100);
        check(n == 16, "R7 full period after early clear", n, 16);
        do_reset(); advance(12); pulse_clr();
        check(!rst_req_o, "R7 clear at window start accepted", int'(rst_req_o), 0);
        measure(n, 100);
        check(n == 16, "R4 clear restarts counts", n, 16);
        do_reset(); advance(15); pulse_clr();
        check(!rst_req_o && !wake_o, "R7 clear on last tick cancels timeout",
              int'(rst_req_o | wake_o), 0);
        win_dis_i = 1'b1;
        do_reset(); advance(1); pulse_clr();
        check(!rst_req_o, "R8 clear anywhere when window off", int'(rst_req_o), 0);
        measure(n, 100);
        check(n == 16, "R8 period after unwindowed clear", n, 16);
    endtask

    task automatic t_events();
        int n;
        do_reset(); advance(10);
        clk_sw_done_i = 1'b1; advance(1); clk_sw_done_i = 1'b0;
        measure(n, 100);
        check(n == 16, "R4 clock switch restarts", n, 16);
        do_reset(); advance(13);
        ps_enter_i = 1'b1; advance(1); ps_enter_i = 1'b0;
        measure(n, 100);
        check(n == 16, "R4 power-save entry restarts", n, 16);
        do_reset(); advance(7);
        ps_exit_i = 1'b1; advance(1); ps_exit_i = 1'b0;
        measure(n, 100);
        check(n == 16, "R4 power-save exit restarts", n, 16);
    endtask

    task automatic t_enable();
        int n;
        int seen;
        hw_en_i = 1'b0; sw_en_i = 1'b0; do_reset();
        seen = 0;
        for (int i = 0; i < 100; i++) begin
            advance(1);
            if (rst_req_o || wake_o) seen++;
        end
        check(seen == 0, "R6 disabled raises nothing", seen, 0);
        sw_en_i = 1'b1;
        measure(n, 100);
        check(n == 16, "R5 software enable runs", n, 16);
        advance(10);
        sw_en_i = 1'b0; advance(3); sw_en_i = 1'b1;
        measure(n, 100);
        check(n == 16, "R6 counts held at zero while off", n, 16);
        hw_en_i = 1'b1; sw_en_i = 1'b0; do_reset();
        measure(n, 100);
        check(n == 16, "R5 hardware enable overrides", n, 16);
    endtask

    task automatic t_low_power();
        int n;
        low_power_i = 1'b1; do_reset();
        measure(n, 100);
        check(n == 16 && wake_o && !rst_req_o, "R9 wake instead of reset", n, 16);
        check(flag_o, "R10 flag set on wake timeout", int'(flag_o), 1);
        advance(5);
        check(flag_o, "R10 flag sticky", int'(flag_o), 1);
        flag_clr_i = 1'b1; advance(1); flag_clr_i = 1'b0;
        check(!flag_o, "R10 flag cleared by software", int'(flag_o), 0);
        measure(n, 100);
        check(n == 10 && wake_o, "R9 next wake timeout", n, 10);
        check(flag_o, "R10 flag sets again", int'(flag_o), 1);
        low_power_i = 1'b0;
    endtask

    task automatic t_tick_gap();
        int n;
        tick_gap = 1'b1; do_reset();
        measure(n, 200);
        check(n == 31 || n == 32, "R11 counts only on ticks", n, 32);
        tick_gap = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        t_reset_state();
        t_prescaler();
        t_postscaler();
        t_run_timeout();
        t_window();
        t_events();
        t_enable();
        t_low_power();
        t_tick_gap();
        finish_run();
    end

endmodule